// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block decides, in every cycle, whether the instruction waiting in the fetch/decode latch of a five-stage in-order pipeline may advance. It looks at the decoded fields that sit in the fetch/decode latch, in the decode/execute latch and in the three internal latches of a four-stage pipelined multiplier. From these it raises a single hold decision. The hold freezes the program counter and the fetch/decode latch, and it injects an empty slot into the decode/execute latch.

The rest of the pipeline forwards results fully from every later stage. The unit therefore only holds for the cases that forwarding cannot cover. The first is a load whose result is needed at once. The second is a source register still being produced inside the multiplier. The third is a clash with the multiplier for the single register-file write port. The fourth is a younger write that would land before an older multiply aimed at the same register. The decision is purely combinational from the latch contents. Because the held instruction stays in place, it is judged again in the next cycle.

Top module: `interlock_ctl`

## Requirements
- R1: Operation classes are encoded on two bits as 0 = ALU, 1 = load, 2 = store, 3 = multiply. A hold is raised when the decode/execute instruction is a load and its live destination equals the live first source of the fetch/decode instruction. A hold is also raised when that destination equals the live second source and the fetch/decode instruction is not a store.
- R2: A store whose only dependence is its second (data) source on a load in decode/execute is not held.
- R3: A hold is raised when either live fetch/decode source equals a live destination in any multiplier latch (index 0 = first latch through index MUL_LAT-1 = last). A hold is also raised when either source equals the live destination of a multiply sitting in decode/execute.
- R4: A hold is raised when the fetch/decode instruction has a live destination, is not a multiply, and multiplier latch index 0 holds a live destination (write-port conflict).
- R5: A hold is raised when the live fetch/decode destination equals the live decode/execute destination and the decode/execute instruction is a multiply.
- R6: A register field is live only when its valid flag is 1 and its number is not zero. Fields that are not live never cause a hold, and register 0 never matches.
- R7: While held, `pc_we` and `fd_we` are 0 and `dx_bubble` is 1. Otherwise `pc_we` and `fd_we` are 1 and `dx_bubble` is 0. All four outputs follow the inputs in the same cycle.
- R8: No other condition raises a hold. In particular, a dependence on an ALU or store result in decode/execute, or on a load two stages ahead, is left to forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the built-in checks |
| rst_n | input | 1 | Active-low reset, disables the built-in checks |
| fd_rs1 | input | REG_BITS | Fetch/decode first source register |
| fd_rs1_vld | input | 1 | First source is used |
| fd_rs2 | input | REG_BITS | Fetch/decode second source register |
| fd_rs2_vld | input | 1 | Second source is used |
| fd_rd | input | REG_BITS | Fetch/decode destination register |
| fd_rd_vld | input | 1 | Destination is written |
| fd_op | input | 2 | Fetch/decode operation class |
| dx_rd | input | REG_BITS | Decode/execute destination register |
| dx_rd_vld | input | 1 | Decode/execute destination is written |
| dx_op | input | 2 | Decode/execute operation class |
| mq_rd | input | MUL_LAT x REG_BITS | Destinations in the multiplier latches, index 0 youngest |
| mq_rd_vld | input | MUL_LAT | Valid flags of the multiplier destinations |
| stall | output | 1 | Hold the fetch/decode instruction |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode latch write enable |
| dx_bubble | output | 1 | Load an empty slot into decode/execute |

## Verification
The bench uses two-bit register numbers. It sweeps every combination of fetch/decode fields against every decode/execute destination and class, then mixes random multiplier-latch contents on top.

The store-data exemption is a targeted case. A design that ignored it would hold stores behind loads needlessly. A design that applied it to the first source would let a store read a stale address.

Register 0 and cleared valid flags are covered too. Forgetting either would produce phantom holds behind bubbles and zero-register writes.

The multiplier cases probe two further errors. Checking only the first multiplier latch would let a dependent instruction read a product that is not finished. Mis-gating the write-port rule would either lose a write or hold every instruction behind a multiply.

// File: rtl/interlock_ctl.sv
module interlock_ctl #(
  parameter int REG_BITS = 5,
  parameter int MUL_LAT  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [REG_BITS-1:0]                fd_rs1,
  input  logic                               fd_rs1_vld,
  input  logic [REG_BITS-1:0]                fd_rs2,
  input  logic                               fd_rs2_vld,
  input  logic [REG_BITS-1:0]                fd_rd,
  input  logic                               fd_rd_vld,
  input  logic [1:0]                         fd_op,
  input  logic [REG_BITS-1:0]                dx_rd,
  input  logic                               dx_rd_vld,
  input  logic [1:0]                         dx_op,
  input  logic [MUL_LAT-1:0][REG_BITS-1:0]   mq_rd,
  input  logic [MUL_LAT-1:0]                 mq_rd_vld,
  output logic                               stall,
  output logic                               pc_we,
  output logic                               fd_we,
  output logic                               dx_bubble
);

  localparam logic [1:0] OP_ALU   = 2'd0;
  localparam logic [1:0] OP_LOAD  = 2'd1;
  localparam logic [1:0] OP_STORE = 2'd2;
  localparam logic [1:0] OP_MUL   = 2'd3;

  logic s1_live, s2_live, rd_live, dx_live;
  logic dx_hit1, dx_hit2;
  logic load_use, dx_mul_dep, mq_dep, port_clash, waw_mul;
  logic [MUL_LAT-1:0] mq_live, mq_hit;

  assign s1_live = fd_rs1_vld && (fd_rs1 != '0);
  assign s2_live = fd_rs2_vld && (fd_rs2 != '0);
  assign rd_live = fd_rd_vld  && (fd_rd  != '0);
  assign dx_live = dx_rd_vld  && (dx_rd  != '0);

  assign dx_hit1 = s1_live && dx_live && (fd_rs1 == dx_rd);
  assign dx_hit2 = s2_live && dx_live && (fd_rs2 == dx_rd);

  assign load_use   = (dx_op == OP_LOAD) && (dx_hit1 || (dx_hit2 && fd_op != OP_STORE));
  assign dx_mul_dep = (dx_op == OP_MUL) && (dx_hit1 || dx_hit2);

  for (genvar i = 0; i < MUL_LAT; i++) begin : g_mq
    assign mq_live[i] = mq_rd_vld[i] && (mq_rd[i] != '0);
    assign mq_hit[i]  = mq_live[i] &&
                        ((s1_live && fd_rs1 == mq_rd[i]) || (s2_live && fd_rs2 == mq_rd[i]));
  end

  assign mq_dep     = (|mq_hit) || dx_mul_dep;
  assign port_clash = rd_live && (fd_op != OP_MUL) && mq_live[0];
  assign waw_mul    = rd_live && dx_live && (fd_rd == dx_rd) && (dx_op == OP_MUL);

  assign stall     = load_use || mq_dep || port_clash || waw_mul;
  assign pc_we     = ~stall;
  assign fd_we     = ~stall;
  assign dx_bubble = stall;

  assert_load_src1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_op == OP_LOAD && dx_rd_vld && dx_rd != '0 && fd_rs1_vld && fd_rs1 == dx_rd) |-> stall);

  assert_mul_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mq_rd_vld[MUL_LAT-1] && mq_rd[MUL_LAT-1] != '0 && fd_rs2_vld && fd_rs2 == mq_rd[MUL_LAT-1]) |-> stall);

  assert_write_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_rd_vld && fd_rd != '0 && fd_op != OP_MUL && mq_rd_vld[0] && mq_rd[0] != '0) |-> stall);

  assert_waw_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_op == OP_MUL && dx_rd_vld && fd_rd_vld && fd_rd == dx_rd && fd_rd != '0) |-> stall);

  assert_dead_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_rs1_vld && !fd_rs2_vld && !fd_rd_vld) |-> !stall);

  assert_hold_controls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_we && !fd_we && dx_bubble));

  assert_no_producer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dx_rd_vld && mq_rd_vld == '0) |-> !stall);

  assert_alu_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_op == OP_ALU && mq_rd_vld == '0) |-> !stall);

endmodule

// File: tb/test_interlock_ctl.sv
module test_interlock_ctl;
  localparam int RB = 2;
  localparam int ML = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RB-1:0] fd_rs1 = '0, fd_rs2 = '0, fd_rd = '0, dx_rd = '0;
  logic fd_rs1_vld = 1'b0, fd_rs2_vld = 1'b0, fd_rd_vld = 1'b0, dx_rd_vld = 1'b0;
  logic [1:0] fd_op = 2'd0, dx_op = 2'd0;
  logic [ML-1:0][RB-1:0] mq_rd = '0;
  logic [ML-1:0] mq_rd_vld = '0;
  logic stall, pc_we, fd_we, dx_bubble;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interlock_ctl #(.REG_BITS(RB), .MUL_LAT(ML)) i_interlock_ctl (
    .clk(clk), .rst_n(rst_n),
    .fd_rs1(fd_rs1), .fd_rs1_vld(fd_rs1_vld), .fd_rs2(fd_rs2), .fd_rs2_vld(fd_rs2_vld),
    .fd_rd(fd_rd), .fd_rd_vld(fd_rd_vld), .fd_op(fd_op),
    .dx_rd(dx_rd), .dx_rd_vld(dx_rd_vld), .dx_op(dx_op),
    .mq_rd(mq_rd), .mq_rd_vld(mq_rd_vld),
    .stall(stall), .pc_we(pc_we), .fd_we(fd_we), .dx_bubble(dx_bubble));

  task automatic check_now();
    bit a1, a2, ad, xd, e_lu, e_mq, e_port, e_waw, e_st;
    bit [3:0] got, exp;
    string tag;
    a1 = fd_rs1_vld && fd_rs1 != 0;
    a2 = fd_rs2_vld && fd_rs2 != 0;
    ad = fd_rd_vld && fd_rd != 0;
    xd = dx_rd_vld && dx_rd != 0;
    // R1 and R2: load followed by a use, store data exempt
    e_lu = (dx_op == 2'd1) && xd &&
           ((a1 && fd_rs1 == dx_rd) || (a2 && fd_rs2 == dx_rd && fd_op != 2'd2));
    // R3: in-flight multiply in decode/execute or any multiplier latch
    e_mq = (dx_op == 2'd3) && xd && ((a1 && fd_rs1 == dx_rd) || (a2 && fd_rs2 == dx_rd));
    for (int k = 0; k < ML; k++)
      if (mq_rd_vld[k] && mq_rd[k] != 0 &&
          ((a1 && fd_rs1 == mq_rd[k]) || (a2 && fd_rs2 == mq_rd[k])))
        e_mq = 1'b1;
    // R4: write-port conflict
    e_port = ad && fd_op != 2'd3 && mq_rd_vld[0] && mq_rd[0] != 0;
    // R5: write ordering behind a multiply
    e_waw = ad && xd && fd_rd == dx_rd && dx_op == 2'd3;
    e_st = e_lu || e_mq || e_port || e_waw;
    if (e_lu) tag = "R1";
    else if (e_mq) tag = "R3";
    else if (e_port) tag = "R4";
    else if (e_waw) tag = "R5";
    else if (fd_op == 2'd2 && dx_op == 2'd1) tag = "R2";
    else tag = "R6/R8";
    got = {stall, pc_we, fd_we, dx_bubble};
    exp = {e_st, !e_st, !e_st, e_st};   // R7 output relation
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s R7 outputs actual=%b expected=%b (fd %0d/%0d/%0d op%0d dx %0d op%0d)",
               tag, got, exp, fd_rs1, fd_rs2, fd_rd, fd_op, dx_rd, dx_op);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // reset state: all fields dead, R6 and R7 say no hold
    @(negedge clk); #1;
    check_now();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R6: register 0 marked valid on both sides never matches
    @(negedge clk);
    fd_rs1 = 0; fd_rs1_vld = 1; dx_rd = 0; dx_rd_vld = 1; dx_op = 2'd1;
    #1; check_now();

    // R2: store data source behind a load, address source clean
    @(negedge clk);
    fd_rs1 = 2; fd_rs1_vld = 1; fd_rs2 = 3; fd_rs2_vld = 1; fd_op = 2'd2;
    fd_rd_vld = 0; dx_rd = 3; dx_rd_vld = 1; dx_op = 2'd1;
    #1; check_now();

    // R1, R2, R5, R6, R8: every fetch/decode field against every decode/execute entry
    mq_rd_vld = '0;
    for (int f = 0; f < 2048; f++) begin
      for (int x = 0; x < 32; x++) begin
        @(negedge clk);
        {fd_rs1, fd_rs1_vld, fd_rs2, fd_rs2_vld, fd_rd, fd_rd_vld, fd_op} = f[10:0];
        {dx_rd, dx_rd_vld, dx_op} = x[4:0];
        #1; check_now();
      end
    end

    // R3, R4: random multiplier latch occupancy on top of random fields
    for (int n = 0; n < 30000; n++) begin
      @(negedge clk);
      {fd_rs1, fd_rs1_vld, fd_rs2, fd_rs2_vld, fd_rd, fd_rd_vld, fd_op} = 11'($urandom);
      {dx_rd, dx_rd_vld, dx_op} = 5'($urandom);
      mq_rd = 6'($urandom);
      mq_rd_vld = 3'($urandom);
      #1; check_now();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule